// File: doc/BRIEF.md
# Serial Bus Event Interrupt and Vector Unit

This unit keeps the event status word of a serial bus controller, the interrupt enable mask that goes with it, and the per-direction DMA enables. A single level interrupt is raised whenever any enabled event is pending. A host that prefers not to scan the status word reads a vector register. That read returns the number of the lowest pending enabled event and acknowledges only that event.

Event pulses come in from the neighbouring data buffer and transfer sequencer and are merged into status every cycle. The receive-ready and transmit-ready events are cleared only by those neighbours or by a vector read. When DMA is enabled for a direction, the ready bit of that direction drives that direction's request line. Enabling DMA also masks the matching ready interrupt, so the processor and the DMA engine do not both service the same event. A build parameter selects one of two register revisions. The newer revision adds write-one-to-clear status, a sixth enable bit and a forced-status test trigger.

Top module: `ser_evt_irq_unit`

## Requirements
- R1: `irq` is high exactly when the stored status AND the enable mask is nonzero. With an all-zero mask it stays low.
- R2: A read of the vector register (offset 2) returns one plus the index of the lowest set bit of status AND mask, or 0 when none is set. The same read clears that one status bit and no other.
- R3: The DMA control register (offset 3) stores only bit 15 (receive DMA on) and bit 7 (transmit DMA on). Every other bit reads back as zero.
- R4: `rx_dreq` equals receive DMA on AND status bit 3 (receive ready). `tx_dreq` equals transmit DMA on AND status bit 4 (transmit ready). Both are low while their DMA bit is off.
- R5: A DMA control write with bit 15 set clears enable bit 3. A DMA control write with bit 7 set clears enable bit 4.
- R6: On the newer revision, a status write (offset 1) clears the status bits that are 1 in the written value AND 0x0027. On the older revision a status write has no effect. Bits 3 and 4 are never cleared by a status write.
- R7: The enable register (offset 0) keeps the low 6 bits on the newer revision and the low 5 bits on the older one. The other bits read as zero.
- R8: Status bit 12 always reads as the live `bus_busy` input. It is never stored, even when an event pulse targets it.
- R9: On the newer revision, a write to the test register (offset 4) with bit 11 set sets status bits 0x003F. Such a write has no effect on the older revision or when bit 11 is clear.
- R10: Event pulses on `evt_set` are ORed into status at the next clock edge. A status-write clear or a vector-read clear in the same cycle loses to the pulse.
- R11: Synchronous active-low reset clears status, mask and both DMA enables.
- R12: Reads of offsets 5 to 7 return zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (needed for vector acknowledge) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the current offset |
| evt_set | input | 16 | One-cycle event set pulses, one per status bit |
| bus_busy | input | 1 | Live bus-busy level, shown as status bit 12 |
| irq | output | 1 | Level interrupt |
| rx_dreq | output | 1 | Receive DMA request |
| tx_dreq | output | 1 | Transmit DMA request |

## Verification
The assertions assume that a read strobe and a write strobe share one offset, so a vector acknowledge and a status write never happen in the same cycle. The stimulus never raises both strobes together. The vector-clear property is checked only in cycles with no event pulse, because a pulse would legally put the bit back. The bench keeps every pulse-plus-clear collision in separate, directed cycles, and the broad status-by-mask sweep runs with `evt_set` idle during the vector reads.

// File: rtl/ser_evt_pkg.sv
// Shared constants for the serial bus event interrupt unit.
// Bit positions are fixed by the neighbouring blocks that raise the events.
package ser_evt_pkg;
    localparam int unsigned REG_W  = 16;
    localparam int unsigned ADDR_W = 3;

    localparam logic [ADDR_W-1:0] OFS_ENABLE = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_STATUS = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_VECTOR = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_DMA    = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_FORCE  = 3'd4;

    localparam int unsigned RX_RDY_BIT   = 3;
    localparam int unsigned TX_RDY_BIT   = 4;
    localparam int unsigned BUSY_BIT     = 12;
    localparam int unsigned RX_DMA_BIT   = 15;
    localparam int unsigned TX_DMA_BIT   = 7;
    localparam int unsigned FORCE_TRIG   = 11;

    localparam logic [REG_W-1:0] SW_CLR_MASK   = 16'h0027;
    localparam logic [REG_W-1:0] FORCE_PATTERN = 16'h003F;
    localparam logic [REG_W-1:0] STORE_MASK    = ~(16'h0001 << BUSY_BIT);
endpackage

// File: rtl/ser_evt_status_reg.sv
// Event status storage.
// Assumes set and clear vectors are already qualified; set wins over clear.
// The busy position is never stored (it is shown live by the read mux).
module ser_evt_status_reg
    import ser_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] set_i,
    input  logic [REG_W-1:0] clr_i,
    output logic [REG_W-1:0] st_q
);
    // Merge clears then sets each cycle; drop the unstored bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= ((st_q & ~clr_i) | set_i) & STORE_MASK;
        end
    end
endmodule

// File: rtl/ser_evt_mask_ctl.sv
// Interrupt enable mask and per-direction DMA enables.
// Assumes MASK_W is at least 5 so both ready positions exist in the mask.
// Turning DMA on for a direction drops that direction's ready enable.
module ser_evt_mask_ctl
    import ser_evt_pkg::*;
#(
    parameter int unsigned MASK_W = 6
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_wr,
    input  logic [MASK_W-1:0] en_val,
    input  logic              dma_wr,
    input  logic              rx_on_val,
    input  logic              tx_on_val,
    output logic [MASK_W-1:0] mask_q,
    output logic              rx_on_q,
    output logic              tx_on_q
);
    // Register enable writes and DMA writes with their side effect on the mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '0;
            rx_on_q <= 1'b0;
            tx_on_q <= 1'b0;
        end else begin
            if (en_wr) begin
                mask_q <= en_val;
            end
            if (dma_wr) begin
                rx_on_q <= rx_on_val;
                tx_on_q <= tx_on_val;
                if (rx_on_val) begin
                    mask_q[RX_RDY_BIT] <= 1'b0;
                end
                if (tx_on_val) begin
                    mask_q[TX_RDY_BIT] <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/ser_evt_vector.sv
// Lowest-first priority pick over the pending enabled events.
// Purely combinational; vec_o is index+1 of the winner, 0 when idle.
module ser_evt_vector #(
    parameter int unsigned N     = 6,
    parameter int unsigned VEC_W = 3
)(
    input  logic [N-1:0]     pend_i,
    output logic [N-1:0]     pick_o,
    output logic [VEC_W-1:0] vec_o
);
    genvar g;
    // One-hot winner: a bit wins when nothing below it is pending.
    generate
        for (g = 0; g < N; g++) begin : g_pick
            if (g == 0) begin : g_first
                assign pick_o[g] = pend_i[g];
            end else begin : g_rest
                assign pick_o[g] = pend_i[g] & ~(|pend_i[g-1:0]);
            end
        end
    endgenerate

    // Encode the one-hot winner as index plus one.
    always_comb begin
        vec_o = '0;
        for (int i = 0; i < N; i++) begin
            if (pick_o[i]) begin
                vec_o = VEC_W'(i + 1);
            end
        end
    end
endmodule

// File: rtl/ser_evt_irq_unit.sv
// Serial bus event interrupt and vector unit (top).
// Decodes the 16-bit register port, merges event pulses into status,
// drives the level interrupt and the two DMA request lines.
// Assumes reg_rd and reg_wr are never high together; read data is
// combinational from the current state and the offset.
module ser_evt_irq_unit
    import ser_evt_pkg::*;
#(
    parameter bit          NEW_REV    = 1'b1,
    parameter int unsigned VEC_EVENTS = 6
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [REG_W-1:0]  evt_set,
    input  logic              bus_busy,
    output logic              irq,
    output logic              rx_dreq,
    output logic              tx_dreq
);
    localparam int unsigned MASK_W = NEW_REV ? VEC_EVENTS : VEC_EVENTS - 1;
    localparam int unsigned VEC_W  = $clog2(VEC_EVENTS + 1);

    logic [REG_W-1:0]  st_q;
    logic [MASK_W-1:0] mask_q;
    logic              rx_on_q;
    logic              tx_on_q;
    logic [MASK_W-1:0] pend;
    logic [MASK_W-1:0] pick;
    logic [VEC_W-1:0]  vec;
    logic [REG_W-1:0]  set_all;
    logic [REG_W-1:0]  clr_all;
    logic              wr_en, wr_stat, wr_dma, wr_force, rd_vec;

    // Strobe decode per offset.
    always_comb begin
        wr_en    = reg_wr && (reg_addr == OFS_ENABLE);
        wr_stat  = reg_wr && (reg_addr == OFS_STATUS);
        wr_dma   = reg_wr && (reg_addr == OFS_DMA);
        wr_force = reg_wr && (reg_addr == OFS_FORCE);
        rd_vec   = reg_rd && (reg_addr == OFS_VECTOR);
    end

    // Build the set and clear vectors for the status register.
    always_comb begin
        set_all = evt_set;
        if (NEW_REV && wr_force && reg_wdata[FORCE_TRIG]) begin
            set_all = set_all | FORCE_PATTERN;
        end
        clr_all = '0;
        if (NEW_REV && wr_stat) begin
            clr_all = reg_wdata & SW_CLR_MASK;
        end
        if (rd_vec) begin
            clr_all[MASK_W-1:0] = pick;
        end
    end

    ser_evt_status_reg u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_all),
        .clr_i (clr_all),
        .st_q  (st_q)
    );

    ser_evt_mask_ctl #(.MASK_W(MASK_W)) u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_wr     (wr_en),
        .en_val    (reg_wdata[MASK_W-1:0]),
        .dma_wr    (wr_dma),
        .rx_on_val (reg_wdata[RX_DMA_BIT]),
        .tx_on_val (reg_wdata[TX_DMA_BIT]),
        .mask_q    (mask_q),
        .rx_on_q   (rx_on_q),
        .tx_on_q   (tx_on_q)
    );

    // Pending enabled events feed both the interrupt and the vector.
    always_comb begin
        pend = st_q[MASK_W-1:0] & mask_q;
    end

    ser_evt_vector #(.N(MASK_W), .VEC_W(VEC_W)) u_vec (
        .pend_i (pend),
        .pick_o (pick),
        .vec_o  (vec)
    );

    // Output levels.
    always_comb begin
        irq     = |pend;
        rx_dreq = rx_on_q & st_q[RX_RDY_BIT];
        tx_dreq = tx_on_q & st_q[TX_RDY_BIT];
    end

    // Read mux by offset.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_ENABLE: reg_rdata[MASK_W-1:0] = mask_q;
            OFS_STATUS: begin
                reg_rdata           = st_q;
                reg_rdata[BUSY_BIT] = bus_busy;
            end
            OFS_VECTOR: reg_rdata = REG_W'(vec);
            OFS_DMA: begin
                reg_rdata[RX_DMA_BIT] = rx_on_q;
                reg_rdata[TX_DMA_BIT] = tx_on_q;
            end
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ser_evt_irq_unit_chk.sv
// Property checker for ser_evt_irq_unit, bound to every instance.
// Assumes read and write strobes are not raised together.
module ser_evt_irq_unit_chk
    import ser_evt_pkg::*;
#(
    parameter int unsigned MASK_W = 6
)(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic              wdata_rx_on,
    input logic [REG_W-1:0]  reg_rdata,
    input logic [REG_W-1:0]  evt_set,
    input logic              bus_busy,
    input logic              irq,
    input logic              rx_dreq,
    input logic              tx_dreq,
    input logic [REG_W-1:0]  st_q,
    input logic [MASK_W-1:0] mask_q
);
    logic [REG_W-1:0] pick_q;

    // Remember which status bit the current vector value names.
    always_ff @(posedge clk) begin
        pick_q <= REG_W'(1) << (reg_rdata[3:0] - 4'd1);
    end

    a_r1_quiet_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq);

    a_r2_vector_acks: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == OFS_VECTOR && reg_rdata != '0 && evt_set == '0)
        |=> ((st_q & pick_q) == '0));

    a_r4_rx_req_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        rx_dreq |-> st_q[RX_RDY_BIT]);

    a_r4_tx_req_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        tx_dreq |-> st_q[TX_RDY_BIT]);

    a_r5_dma_drops_rx_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_DMA && wdata_rx_on) |=> !mask_q[RX_RDY_BIT]);

    a_r6_ready_not_sw_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_STATUS)
        |=> (st_q[TX_RDY_BIT:RX_RDY_BIT] ==
             ($past(st_q[TX_RDY_BIT:RX_RDY_BIT]) | $past(evt_set[TX_RDY_BIT:RX_RDY_BIT]))));

    a_r8_busy_is_live: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFS_STATUS) |-> (reg_rdata[BUSY_BIT] == bus_busy));

    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_set != '0) |=> ((st_q & $past(evt_set & STORE_MASK)) == $past(evt_set & STORE_MASK)));

    a_r11_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (st_q == '0 && mask_q == '0));
endmodule

bind ser_evt_irq_unit ser_evt_irq_unit_chk #(.MASK_W(MASK_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_addr    (reg_addr),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .wdata_rx_on (reg_wdata[15]),
    .reg_rdata   (reg_rdata),
    .evt_set     (evt_set),
    .bus_busy    (bus_busy),
    .irq         (irq),
    .rx_dreq     (rx_dreq),
    .tx_dreq     (tx_dreq),
    .st_q        (st_q),
    .mask_q      (mask_q)
);

// File: tb/ser_evt_irq_unit_tb_top.sv
// Bench: drives a newer-revision instance (dut_i) and an older-revision
// instance side by side; expected values are computed arithmetically.
module ser_evt_irq_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] evt_set = '0;
    logic        bus_busy = 1'b0;
    logic [15:0] n_rdata, o_rdata;
    logic        n_irq, o_irq, n_rx, o_rx, n_tx, o_tx;
    int          total = 0;
    int          bad = 0;

    always #2 clk = ~clk;

    ser_evt_irq_unit #(.NEW_REV(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(n_rdata),
        .evt_set(evt_set), .bus_busy(bus_busy), .irq(n_irq),
        .rx_dreq(n_rx), .tx_dreq(n_tx));

    ser_evt_irq_unit #(.NEW_REV(1'b0)) old_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(o_rdata),
        .evt_set(evt_set), .bus_busy(bus_busy), .irq(o_irq),
        .rx_dreq(o_rx), .tx_dreq(o_tx));

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge.
    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_wr(input logic [2:0] a, input logic [15:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic do_rd(input logic [2:0] a, output logic [15:0] nv, output logic [15:0] ov);
        reg_addr = a; reg_rd = 1'b1;
        #1;
        nv = n_rdata; ov = o_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic pulse(input logic [15:0] v);
        evt_set = v;
        @(negedge clk);
        evt_set = '0;
    endtask

    function automatic logic [15:0] lowest(input logic [15:0] v);
        for (int i = 0; i < 6; i++) begin
            if (v[i]) return 16'(i + 1);
        end
        return 16'd0;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=running exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] nv, ov, pn, po, ln, lo;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state
        do_rd(3'd0, nv, ov); chk("R11 enable n", nv, 16'h0); chk("R11 enable o", ov, 16'h0);
        do_rd(3'd1, nv, ov); chk("R11 status n", nv, 16'h0); chk("R11 status o", ov, 16'h0);
        do_rd(3'd3, nv, ov); chk("R11 dma n", nv, 16'h0);
        do_rd(3'd2, nv, ov); chk("R11 vector n", nv, 16'h0);
        chk("R11 outs", {13'd0, n_irq, n_rx, n_tx}, 16'h0);

        // R12: unmapped offsets
        do_wr(3'd5, 16'hFFFF); do_wr(3'd7, 16'hFFFF);
        do_rd(3'd7, nv, ov); chk("R12 unmapped read", nv, 16'h0);
        do_rd(3'd1, nv, ov); chk("R12 status untouched", nv, 16'h0);
        do_rd(3'd0, nv, ov); chk("R12 enable untouched", nv, 16'h0);

        // R8: busy is live and never stored
        bus_busy = 1'b1;
        do_rd(3'd1, nv, ov); chk("R8 busy n", nv, 16'h1000); chk("R8 busy o", ov, 16'h1000);
        bus_busy = 1'b0;
        pulse(16'h1000);
        do_rd(3'd1, nv, ov); chk("R8 not stored", nv, 16'h0);

        // R1 R2 R7: sweep of status against mask on both revisions
        for (int m = 0; m < 64; m++) begin
            for (int s = 0; s < 64; s++) begin
                do_reset();
                pulse(16'(s));
                do_wr(3'd0, 16'(m));
                pn = 16'(s & m);
                po = 16'(s & m & 31);
                ln = lowest(pn);
                lo = lowest(po);
                #1;
                chk("R1 irq n", {15'd0, n_irq}, {15'd0, pn != 0});
                chk("R7 R1 irq o", {15'd0, o_irq}, {15'd0, po != 0});
                do_rd(3'd2, nv, ov);
                chk("R2 vector n", nv, ln);
                chk("R7 R2 vector o", ov, lo);
                do_rd(3'd1, nv, ov);
                chk("R2 single clear n", nv, 16'(s) & ~((ln == 0) ? 16'h0 : (16'h1 << (ln - 1))));
            end
        end
        do_reset();
        do_wr(3'd0, 16'hFFFF);
        do_rd(3'd0, nv, ov); chk("R7 enable width n", nv, 16'h003F); chk("R7 enable width o", ov, 16'h001F);

        // R3 R5: DMA control bits and their mask side effect
        do_wr(3'd3, 16'hFFFF);
        do_rd(3'd3, nv, ov); chk("R3 dma readback", nv, 16'h8080);
        do_rd(3'd0, nv, ov); chk("R5 both ready masked n", nv, 16'h0027); chk("R5 both ready masked o", ov, 16'h0007);
        do_wr(3'd0, 16'h003F);
        do_wr(3'd3, 16'h0080);
        do_rd(3'd0, nv, ov); chk("R5 tx ready masked n", nv, 16'h002F); chk("R5 tx ready masked o", ov, 16'h000F);
        do_rd(3'd3, nv, ov); chk("R3 tx only", nv, 16'h0080);

        // R4: request lines
        do_reset();
        do_wr(3'd3, 16'h8080);
        pulse(16'h0018);
        #1 chk("R4 both req", {14'd0, n_rx, n_tx}, 16'h3);
        do_wr(3'd3, 16'h0000);
        #1 chk("R4 none", {14'd0, n_rx, n_tx}, 16'h0);
        do_wr(3'd3, 16'h8000);
        #1 chk("R4 rx only", {14'd0, n_rx, n_tx}, 16'h2);
        do_wr(3'd3, 16'h0080);
        #1 chk("R4 tx only", {14'd0, n_rx, n_tx}, 16'h1);

        // R6: software clear of status
        do_reset();
        pulse(16'h013F);
        do_wr(3'd1, 16'hFFFF);
        do_rd(3'd1, nv, ov); chk("R6 clear n", nv, 16'h0118); chk("R6 ignored o", ov, 16'h013F);

        // R9: forced status
        do_reset();
        do_wr(3'd4, 16'h0800);
        do_rd(3'd1, nv, ov); chk("R9 force n", nv, 16'h003F); chk("R9 no force o", ov, 16'h0000);
        do_reset();
        do_wr(3'd4, 16'hF7FF);
        do_rd(3'd1, nv, ov); chk("R9 no trigger", nv, 16'h0000);

        // R10: set wins over simultaneous clear
        do_reset();
        do_wr(3'd0, 16'h003F);
        pulse(16'h0001);
        evt_set = 16'h0001; reg_addr = 3'd2; reg_rd = 1'b1;
        #1 nv = n_rdata;
        @(negedge clk);
        reg_rd = 1'b0; evt_set = '0;
        chk("R10 vector during set", nv, 16'h0001);
        do_rd(3'd1, nv, ov); chk("R10 kept after vector", nv, 16'h0001);
        evt_set = 16'h0001;
        do_wr(3'd1, 16'h0001);
        evt_set = '0;
        do_rd(3'd1, nv, ov); chk("R10 kept after write", nv, 16'h0001);
        do_wr(3'd1, 16'h0001);
        do_rd(3'd1, nv, ov); chk("R10 R6 plain clear", nv, 16'h0000);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule